// File: doc/BRIEF.md
# Ordered Store Buffer with Load Bypass

This block sits between one processor port and a simple bus without caches. Every store the processor makes is placed in a small queue and written to the bus oldest first. Each bus write finishes only when the bus returns its completion pulse. The processor does not wait for those writes. Loads wait for their data, because a load is outstanding until its response returns.

A mode input picks the ordering rule for each load, at the cycle the block accepts that load. In relaxed mode, a load whose address differs from every store still held in the queue goes to the bus ahead of those stores. A relaxed load whose address matches a queued store is answered from the queue with the youngest matching data, and it does not use the bus. In strict mode a load never passes a store: it waits until the queue is empty and the bus is idle. A fence strobe closes the processor port. The port stays closed until every earlier access has completed on the bus. The block then gives a one-cycle done pulse and opens the port again.

The bus side is a state machine with three states. **BUS_IDLE** does the choosing. It goes to BUS_LOAD if a load is pending and is allowed to go now (relaxed, or strict with the queue empty). Otherwise it goes to BUS_STORE if the queue holds a store. **BUS_STORE** drives the head store and returns to BUS_IDLE on completion, when it also removes the store. **BUS_LOAD** drives the pending load and returns to BUS_IDLE on completion, when it also captures the read data. The fence logic has two states. **FEN_OPEN** moves to FEN_DRAIN on the strobe. **FEN_DRAIN** returns to FEN_OPEN, and pulses done, once the queue is empty, the bus is idle and no load is pending.

Top module: `wbuf_bypass`

## Requirements
- R1: Stores reach the bus as writes in exactly the order the processor issued them.
- R2: In relaxed mode (mode_relaxed = 1 when the load is accepted), a load that matches no queued store is put on the bus as soon as the bus access in progress completes, ahead of every store still waiting in the queue.
- R3: In strict mode (mode_relaxed = 0 when the load is accepted), a load is put on the bus only after every earlier store has completed and buf_empty is 1.
- R4: In relaxed mode, a load whose address equals the address of a queued store returns the data of the youngest such store. cpu_rsp_valid rises in the cycle right after the load is accepted, and no bus read is made.
- R5: cpu_req_ready is 0 for a store while the queue holds DEPTH (default 4) stores. It is also 0 for any request while a load is outstanding. Nothing is lost, and a held store is taken once space frees.
- R6: A store leaves the queue only in the cycle its bus write receives bus_ack. buf_empty is 1 exactly when no store is still waiting for completion.
- R7: After a fence_req pulse, cpu_req_ready stays 0 and fence_done stays 0 until all earlier accesses have completed. fence_done is then a one-cycle pulse, and it never occurs with a store queued or a bus request active.
- R8: Once bus_req_valid is 1, it and bus_req_addr, bus_req_write and bus_req_wdata stay unchanged until the cycle bus_ack is 1.
- R9: A load sent to the bus returns bus_rdata on cpu_rsp_rdata, with cpu_rsp_valid high for one cycle, starting the cycle after bus_ack.
- R10: After reset, buf_empty = 1, cpu_req_ready = 1, and bus_req_valid, cpu_rsp_valid and fence_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_relaxed | input | 1 | 1 = loads may pass queued stores, 0 = strict order; sampled when a load is accepted |
| fence_req | input | 1 | One-cycle fence strobe |
| fence_done | output | 1 | One-cycle pulse when the fence has drained |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted in this cycle when valid is also 1 |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Access address |
| cpu_req_wdata | input | DW | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | DW | Load data |
| bus_req_valid | output | 1 | Bus access active |
| bus_req_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | AW | Bus address |
| bus_req_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Completion pulse for the active access |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| buf_empty | output | 1 | No store waiting for completion |

## Verification
The bench holds bus completions back so that stores pile up. It then checks the order of bus operations around a relaxed load and a strict load. A design that ignored the mode would show the read in the wrong place in the bus log. A design that forwarded stale data would return the older of two stores to the same address. A design that sent a matching load to the bus would show an extra read in the log. The bench fills the queue to its depth and checks that the next store is held back rather than overwriting an entry. It raises a fence with stores held back and checks that the done pulse does not come early and that the port stays closed until the pulse.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_STORE,
        BUS_LOAD
    } bus_state_e;

    typedef enum logic {
        FEN_OPEN,
        FEN_DRAIN
    } fence_state_e;
endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PW'(g)) begin
                addr_q[g] <= push_addr;
                data_q[g] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);

    // walk oldest to youngest; the last match found is the youngest
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = int'(rd_ptr) + k;
            if (idx >= DEPTH) idx = idx - DEPTH;
            if (k < int'(count) && addr_q[idx[PW-1:0]] == look_addr) begin
                hit      = 1'b1;
                hit_data = data_q[idx[PW-1:0]];
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
endmodule

// File: rtl/wbuf_bus_fsm.sv
module wbuf_bus_fsm
    import wbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_pend,
    input  logic          ld_strict,
    input  logic [AW-1:0] ld_addr,
    input  logic          st_avail,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          bus_ack,
    output logic          bus_req_valid,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_addr,
    output logic [DW-1:0] bus_req_wdata,
    output logic          st_pop,
    output logic          ld_done,
    output logic          bus_idle
);
    bus_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: begin
                if (ld_pend && (!ld_strict || !st_avail)) state_nx = BUS_LOAD;
                else if (st_avail)                        state_nx = BUS_STORE;
            end
            BUS_STORE: if (bus_ack) state_nx = BUS_IDLE;
            BUS_LOAD:  if (bus_ack) state_nx = BUS_IDLE;
            default:   state_nx = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_req_valid = 1'b0;
        bus_req_write = 1'b0;
        bus_req_addr  = head_addr;
        bus_req_wdata = head_data;
        st_pop        = 1'b0;
        ld_done       = 1'b0;
        bus_idle      = 1'b0;
        unique case (state)
            BUS_IDLE: bus_idle = 1'b1;
            BUS_STORE: begin
                bus_req_valid = 1'b1;
                bus_req_write = 1'b1;
                st_pop        = bus_ack;
            end
            BUS_LOAD: begin
                bus_req_valid = 1'b1;
                bus_req_addr  = ld_addr;
                bus_req_wdata = '0;
                ld_done       = bus_ack;
            end
            default: bus_idle = 1'b1;
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_ack) |=> (bus_req_valid && $stable(bus_req_addr)
            && $stable(bus_req_write) && $stable(bus_req_wdata))); // R8
endmodule

// File: rtl/wbuf_cpu_side.sv
module wbuf_cpu_side
    import wbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_relaxed,
    input  logic          fence_req,
    output logic          fence_done,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    output logic          cpu_rsp_valid,
    output logic [DW-1:0] cpu_rsp_rdata,
    input  logic          q_full,
    input  logic          q_empty,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    input  logic          ld_done,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_idle,
    output logic          push,
    output logic          ld_pend,
    output logic          ld_strict,
    output logic [AW-1:0] ld_addr
);
    fence_state_e fst, fst_nx;
    logic take, take_ld, drained;

    assign cpu_req_ready = !ld_pend && (fst == FEN_OPEN) && !(cpu_req_write && q_full);
    assign take          = cpu_req_valid && cpu_req_ready;
    assign push          = take && cpu_req_write;
    assign take_ld       = take && !cpu_req_write;
    assign drained       = q_empty && bus_idle && !ld_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) fst <= FEN_OPEN;
        else        fst <= fst_nx;
    end

    always_comb begin
        fst_nx = fst;
        unique case (fst)
            FEN_OPEN:  if (fence_req) fst_nx = FEN_DRAIN;
            FEN_DRAIN: if (drained)   fst_nx = FEN_OPEN;
            default:   fst_nx = FEN_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fence_done    <= 1'b0;
            ld_pend       <= 1'b0;
            ld_strict     <= 1'b0;
            ld_addr       <= '0;
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_rdata <= '0;
        end else begin
            fence_done    <= (fst == FEN_DRAIN) && drained;
            cpu_rsp_valid <= 1'b0;
            if (ld_done) begin
                ld_pend       <= 1'b0;
                cpu_rsp_valid <= 1'b1;
                cpu_rsp_rdata <= bus_rdata;
            end
            if (take_ld) begin
                if (mode_relaxed && fwd_hit) begin
                    cpu_rsp_valid <= 1'b1;
                    cpu_rsp_rdata <= fwd_data;
                end else begin
                    ld_pend   <= 1'b1;
                    ld_strict <= !mode_relaxed;
                    ld_addr   <= cpu_req_addr;
                end
            end
        end
    end

    AST_FENCE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |=> !cpu_req_ready); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> cpu_rsp_valid); // R9
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_relaxed,
    input  logic          fence_req,
    output logic          fence_done,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_rsp_valid,
    output logic [DW-1:0] cpu_rsp_rdata,
    output logic          bus_req_valid,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_addr,
    output logic [DW-1:0] bus_req_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          buf_empty
);
    logic          push, st_pop, q_full, q_empty, fwd_hit;
    logic          ld_pend, ld_strict, ld_done, bus_idle;
    logic [AW-1:0] head_addr, ld_addr;
    logic [DW-1:0] head_data, fwd_data;

    wbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(cpu_req_addr), .push_data(cpu_req_wdata),
        .pop(st_pop), .head_addr(head_addr), .head_data(head_data),
        .full(q_full), .empty(q_empty),
        .look_addr(cpu_req_addr), .hit(fwd_hit), .hit_data(fwd_data)
    );

    wbuf_bus_fsm #(.AW(AW), .DW(DW)) i_bus (
        .clk(clk), .rst_n(rst_n),
        .ld_pend(ld_pend), .ld_strict(ld_strict), .ld_addr(ld_addr),
        .st_avail(!q_empty), .head_addr(head_addr), .head_data(head_data),
        .bus_ack(bus_ack),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .st_pop(st_pop), .ld_done(ld_done), .bus_idle(bus_idle)
    );

    wbuf_cpu_side #(.AW(AW), .DW(DW)) i_cpu (
        .clk(clk), .rst_n(rst_n),
        .mode_relaxed(mode_relaxed), .fence_req(fence_req), .fence_done(fence_done),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .q_full(q_full), .q_empty(q_empty), .fwd_hit(fwd_hit), .fwd_data(fwd_data),
        .ld_done(ld_done), .bus_rdata(bus_rdata), .bus_idle(bus_idle),
        .push(push), .ld_pend(ld_pend), .ld_strict(ld_strict), .ld_addr(ld_addr)
    );

    assign buf_empty = q_empty;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !q_full); // R5
    AST_STRICT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_write && ld_strict) |-> q_empty); // R3
    AST_POP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        st_pop |-> (bus_ack && bus_req_write)); // R6
    AST_FENCE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (q_empty && !bus_req_valid)); // R7
endmodule

// File: tb/test_wbuf_bypass.sv
`timescale 1ns/1ps
module test_wbuf_bypass;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_relaxed = 1'b1;
    logic        fence_req = 1'b0;
    logic        fence_done;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [15:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [15:0] cpu_rsp_rdata;
    logic        bus_req_valid, bus_req_write;
    logic [7:0]  bus_req_addr;
    logic [15:0] bus_req_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        buf_empty;

    int checks = 0;
    int fails = 0;
    bit bus_hold = 1'b0;
    int wcnt = 0;
    int fd_cnt = 0;
    logic [15:0] mem [16];
    logic        log_wr [256];
    logic [7:0]  log_addr [256];
    int log_n = 0;

    always #2 clk = ~clk;

    wbuf_bypass i_wbuf_bypass (
        .clk(clk), .rst_n(rst_n), .mode_relaxed(mode_relaxed),
        .fence_req(fence_req), .fence_done(fence_done),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .bus_req_valid(bus_req_valid),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .buf_empty(buf_empty)
    );

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    // bus model: completion LAT cycles after the request, unless held
    always @(negedge clk) begin
        if (fence_done) fd_cnt++;
        if (bus_ack) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (rst_n && bus_req_valid && !bus_hold) begin
            if (wcnt == LAT - 1) begin
                bus_ack = 1'b1;
                if (bus_req_write) mem[bus_req_addr[3:0]] = bus_req_wdata;
                else               bus_rdata = mem[bus_req_addr[3:0]];
                log_wr[log_n & 255]   = bus_req_write;
                log_addr[log_n & 255] = bus_req_addr;
                log_n++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [15:0] data, output int waited);
        waited = 0;
        @(negedge clk);
        while (!cpu_rsp_valid && waited < 200) begin
            waited++;
            @(negedge clk);
        end
        data = cpu_rsp_rdata;
    endtask

    task automatic wait_drain();
        int n = 0;
        @(negedge clk);
        while ((!buf_empty || bus_req_valid || bus_ack) && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {write, addr, wdata, expected load data}
    localparam logic [36:0] VEC [10] = '{
        {1'b1, 4'h1, 16'h1111, 16'h0000},
        {1'b1, 4'h2, 16'h2222, 16'h0000},
        {1'b0, 4'h1, 16'h0000, 16'h1111},
        {1'b0, 4'h7, 16'h0000, 16'h0000},
        {1'b1, 4'h1, 16'h3333, 16'h0000},
        {1'b0, 4'h1, 16'h0000, 16'h3333},
        {1'b1, 4'h7, 16'h7777, 16'h0000},
        {1'b1, 4'h7, 16'h7070, 16'h0000},
        {1'b0, 4'h7, 16'h0000, 16'h7070},
        {1'b0, 4'h2, 16'h0000, 16'h2222}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int w, base;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 buf_empty", 32'(buf_empty), 1);
        chk("R10 cpu_req_ready", 32'(cpu_req_ready), 1);
        chk("R10 bus_req_valid", 32'(bus_req_valid), 0);
        chk("R10 cpu_rsp_valid", 32'(cpu_rsp_valid), 0);
        chk("R10 fence_done", 32'(fence_done), 0);
        rst_n = 1'b1;
        idle(2);

        // table pass: relaxed (addr 0-7) then strict (addr 8-15)
        for (int pass = 0; pass < 2; pass++) begin
            mode_relaxed = (pass == 0);
            for (int v = 0; v < 10; v++) begin
                logic [7:0] a;
                a = {4'h0, (pass == 1), VEC[v][34:32]};
                cpu_op(VEC[v][36], a, VEC[v][31:16]);
                if (!VEC[v][36]) begin
                    wait_rsp(d, w);
                    chk(pass == 0 ? "R4 R9 relaxed table load" : "R3 R9 strict table load",
                        32'(d), 32'(VEC[v][15:0]));
                end
            end
            wait_drain();
        end

        // R2 relaxed bypass order
        mem[5] = 16'h5555;
        mode_relaxed = 1'b1;
        bus_hold = 1'b1;
        base = log_n;
        cpu_op(1, 8'h01, 16'h000A);
        cpu_op(1, 8'h02, 16'h000B);
        cpu_op(0, 8'h05, 16'h0000);
        idle(4);
        chk("R6 buf_empty while stores unacked", 32'(buf_empty), 0);
        chk("R6 no completion while bus held", 32'(log_n - base), 0);
        chk("R5 ready low with load outstanding", 32'(cpu_req_ready), 0);
        bus_hold = 1'b0;
        wait_rsp(d, w);
        chk("R9 bus load data", 32'(d), 32'h5555);
        wait_drain();
        chk("R2 op0 write a1", {23'b0, log_wr[base & 255], log_addr[base & 255]}, 32'h101);
        chk("R2 op1 read a5 passes store", {23'b0, log_wr[(base+1) & 255], log_addr[(base+1) & 255]}, 32'h005);
        chk("R2 op2 write a2", {23'b0, log_wr[(base+2) & 255], log_addr[(base+2) & 255]}, 32'h102);

        // R3 strict: load waits for both stores
        mode_relaxed = 1'b0;
        bus_hold = 1'b1;
        base = log_n;
        cpu_op(1, 8'h01, 16'h001A);
        cpu_op(1, 8'h02, 16'h001B);
        cpu_op(0, 8'h05, 16'h0000);
        idle(3);
        bus_hold = 1'b0;
        wait_rsp(d, w);
        wait_drain();
        chk("R3 op0 write a1", {23'b0, log_wr[base & 255], log_addr[base & 255]}, 32'h101);
        chk("R3 op1 write a2", {23'b0, log_wr[(base+1) & 255], log_addr[(base+1) & 255]}, 32'h102);
        chk("R3 op2 read a5 last", {23'b0, log_wr[(base+2) & 255], log_addr[(base+2) & 255]}, 32'h005);

        // R4 youngest forwarding, no bus read
        mode_relaxed = 1'b1;
        bus_hold = 1'b1;
        base = log_n;
        cpu_op(1, 8'h03, 16'h00C1);
        cpu_op(1, 8'h03, 16'h00C2);
        cpu_op(1, 8'h04, 16'h00D4);
        cpu_op(0, 8'h03, 16'h0000);
        wait_rsp(d, w);
        chk("R4 youngest data", 32'(d), 32'h00C2);
        chk("R4 response next cycle", 32'(w), 0);
        bus_hold = 1'b0;
        wait_drain();
        chk("R4 only three bus ops", 32'(log_n - base), 3);
        chk("R4 no bus read", 32'(log_wr[base & 255] & log_wr[(base+1) & 255] & log_wr[(base+2) & 255]), 1);

        // R5 full queue holds the next store; R1 order
        bus_hold = 1'b1;
        base = log_n;
        for (int s = 0; s < 4; s++) cpu_op(1, 8'(8 + s), 16'(16'h0100 + s));
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b1;
        cpu_req_addr  = 8'h0C;
        cpu_req_wdata = 16'h0104;
        #0.5;
        chk("R5 ready low when full", 32'(cpu_req_ready), 0);
        cpu_req_valid = 1'b0;
        bus_hold = 1'b0;
        cpu_op(1, 8'h0C, 16'h0104);
        wait_drain();
        for (int s = 0; s < 5; s++)
            chk("R1 store order", {23'b0, log_wr[(base+s) & 255], log_addr[(base+s) & 255]}, 32'(9'h108 + s));
        chk("R1 last data reached bus", 32'(mem[12]), 32'h0104);

        // R7 fence
        bus_hold = 1'b1;
        base = log_n;
        cpu_op(1, 8'h0D, 16'h0E01);
        cpu_op(1, 8'h0E, 16'h0E02);
        fd_cnt = 0;
        @(negedge clk) fence_req = 1'b1;
        @(negedge clk) fence_req = 1'b0;
        idle(4);
        chk("R7 no early done", 32'(fd_cnt), 0);
        chk("R7 port closed", 32'(cpu_req_ready), 0);
        bus_hold = 1'b0;
        w = 0;
        while (!fence_done && w < 100) begin
            w++;
            @(negedge clk);
        end
        chk("R7 done pulse", 32'(fence_done), 1);
        chk("R7 stores done at fence", 32'(log_n - base), 2);
        chk("R7 empty at fence", 32'(buf_empty), 1);
        @(negedge clk);
        chk("R7 one-cycle pulse", 32'(fence_done), 0);
        chk("R7 port reopens", 32'(cpu_req_ready), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule